// File: doc/BRIEF.md
# Block-Cipher Accelerator Control Front-End

This block is the register and sequencing layer of a block-cipher accelerator. It sits between a 32-bit word-addressed CPU bus and a cipher engine. Software sets a control word, loads key and initial-vector words, and moves data through a word-wide input queue and output queue, either by bus accesses or through DMA request/acknowledge pairs. When four input words are queued and the output queue has room for a full 128-bit result, the front-end hands one block to the engine and marks itself busy until the result is pushed back into the output queue.

A separate key-preparation setting of the algorithm field runs one engine pass with no data. When that pass finishes, the hardware clears both busy and the enable bit, so software can poll for the enable bit to drop before it starts decrypting. Both queues can be flushed, but only while the unit is disabled. The real cipher datapath is replaced here by a fixed-latency stub: each output word equals the lane-permuted input word XOR the matching key word, further XORed with the matching initial-vector word when decrypting.

Top module: `cipher_ctrl_top`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the status word (address 1) reads 1 (input-not-full only), the DMA-enable word (address 2) reads 0, and both DMA requests are low.
- R2: The control word keeps enable in bit 0, direction in bit 1, algorithm in bits 5:2, key size in bits 7:6 and lane permutation in bits 9:8, and reads back as written; the flush bit 10 always reads 0. Key words (addresses 8 to 15), initial-vector words (16 to 19) and DMA enables (address 2, bit 0 input, bit 1 output) read back as written.
- R3: A processed block gives output word i = P(input word i) XOR key word i, also XORed with initial-vector word i when direction is 1 (decrypt). P is chosen by the permutation field: 0 none, 1 swap 16-bit halves, 2 reverse byte order, 3 reverse bit order.
- R4: While enabled with an algorithm other than 7, the engine accepts a block when at least four input words are queued, the output queue has room for four, and it is idle. Busy (status bit 2) rises one cycle after the edge that queued the fourth word and stays high for LATENCY cycles. The four results are readable LATENCY+1 cycles after that edge, at which point busy falls.
- R5: Algorithm value 7 with enable set runs a key-preparation pass. Busy is high for LATENCY cycles, then busy and the enable bit both clear while the other control fields are kept. No queue contents change.
- R6: Writing the control word with bit 10 set empties both queues only when the enable bit is 0 before the write and in the written value; otherwise the flush has no effect on either queue.
- R7: Status bit 0 is high while the input queue holds fewer than 8 words; status bit 1 is high while the output queue holds at least one word.
- R8: The input DMA request is high when enabled, input DMA is enabled and the input queue is not full. An input acknowledge queues the input DMA data word. The output DMA request is high when output DMA is enabled and the output queue is not empty. An output acknowledge removes the word shown on the output DMA data port.
- R9: A data write (address 3) to a full input queue is dropped. A read of the output data word (address 4) from an empty output queue returns 0 and leaves the queue unchanged.
- R10: Two queued blocks are processed in arrival order, and the output words come out in the same order as the input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the output queue at address 4) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| dma_in_req | output | 1 | Input DMA request |
| dma_in_ack | input | 1 | Input DMA acknowledge; queues dma_in_data |
| dma_in_data | input | 32 | Input DMA data word |
| dma_out_req | output | 1 | Output DMA request |
| dma_out_ack | input | 1 | Output DMA acknowledge; removes the head word |
| dma_out_data | output | 32 | Head of the output queue (0 when empty) |

## Verification
Reads are combinational, so register, status and DMA request values are compared at the falling edge right after the rising edge that caused them. The block path is timed from the rising edge that queues the fourth word: busy is sampled one cycle later and again after LATENCY cycles, while results are checked only after LATENCY+1 cycles, when the output-not-empty flag must just have risen. Key preparation follows the same count from the control write. Flush, overflow and empty-read behaviour is judged through later data and status values, not through internal state.

// File: rtl/cipher_ctrl_pkg.sv
package cipher_ctrl_pkg;

    localparam int BLK_WORDS = 4;
    localparam int KEY_WORDS = 8;

    localparam logic [4:0] A_CTRL  = 5'd0;
    localparam logic [4:0] A_STAT  = 5'd1;
    localparam logic [4:0] A_DMAEN = 5'd2;
    localparam logic [4:0] A_DIN   = 5'd3;
    localparam logic [4:0] A_DOUT  = 5'd4;
    localparam logic [4:0] A_KEY0  = 5'd8;
    localparam logic [4:0] A_IV0   = 5'd16;

    localparam logic [3:0] ALGO_KEYPREP = 4'd7;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_HALF = 2'd1,
        LANE_BYTE = 2'd2,
        LANE_BIT  = 2'd3
    } lane_e;

    typedef struct packed {
        lane_e      lane;
        logic [1:0] keysz;
        logic [3:0] algo;
        logic       dir;
        logic       en;
    } ctrl_t;

    function automatic logic [31:0] lane_permute(input logic [31:0] w, input lane_e m);
        logic [31:0] r;
        case (m)
            LANE_HALF: r = {w[15:0], w[31:16]};
            LANE_BYTE: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            LANE_BIT: begin
                for (int b = 0; b < 32; b++) r[b] = w[31-b];
            end
            default:   r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int BLK   = 4,
    parameter int PEEK  = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    push1,
    input  logic [W-1:0]            din1,
    input  logic                    push_blk,
    input  logic [BLK-1:0][W-1:0]   din_blk,
    input  logic                    pop1,
    input  logic                    pop_blk,
    output logic [PEEK-1:0][W-1:0]  head,
    output logic [CW-1:0]           count
);
    localparam logic [CW-1:0] BLK_C   = CW'(BLK);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] push_n, pop_n;

    always_comb begin
        push_n = push_blk ? BLK_C : (push1 ? CW'(1) : '0);
        pop_n  = pop_blk  ? BLK_C : (pop1  ? CW'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            count <= count + push_n - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_blk) begin
                for (int i = 0; i < BLK; i++) mem[wp + AW'(i)] <= din_blk[i];
            end else if (push1) begin
                mem[wp] <= din1;
            end
        end
    end

    for (genvar g = 0; g < PEEK; g++) begin : g_peek
        assign head[g] = mem[rp + AW'(g)];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push1 || push_blk) && !flush |-> (count - pop_n) + push_n <= DEPTH_C); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop1 || pop_blk) && !flush |-> pop_n <= count); // R9

endmodule

// File: rtl/stub_engine.sv
module stub_engine
    import cipher_ctrl_pkg::*;
#(
    parameter int W   = 32,
    parameter int BLK = 4,
    parameter int LAT = 4,
    localparam int LW = $clog2(LAT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [BLK-1:0][W-1:0]  blk_in,
    input  logic [BLK-1:0][W-1:0]  key,
    input  logic [BLK-1:0][W-1:0]  iv,
    input  logic                   dir,
    input  lane_e                  lane,
    output logic                   busy,
    output logic                   done,
    output logic [BLK-1:0][W-1:0]  result
);
    logic [LW-1:0]          cnt;
    logic [BLK-1:0][W-1:0]  calc;

    for (genvar g = 0; g < BLK; g++) begin : g_word
        assign calc[g] = lane_permute(blk_in[g], lane) ^ key[g] ^ (dir ? iv[g] : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            result <= '0;
        end else if (start) begin
            cnt    <= LW'(LAT);
            result <= calc;
        end else if (cnt != '0) begin
            cnt    <= cnt - LW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == LW'(1));

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R4
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R4

endmodule

// File: rtl/cipher_ctrl_top.sv
module cipher_ctrl_top
    import cipher_ctrl_pkg::*;
#(
    parameter int W       = 32,
    parameter int DEPTH   = 8,
    parameter int LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [4:0]    bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          dma_in_req,
    input  logic          dma_in_ack,
    input  logic [W-1:0]  dma_in_data,
    output logic          dma_out_req,
    input  logic          dma_out_ack,
    output logic [W-1:0]  dma_out_data
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] BLK_C   = CW'(BLK_WORDS);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ROOM_C  = CW'(DEPTH - BLK_WORDS);

    ctrl_t                        ctrl_q;
    logic [1:0]                   dmaen_q;
    logic [W-1:0]                 key_q [KEY_WORDS];
    logic [BLK_WORDS-1:0][W-1:0]  iv_q;
    logic [BLK_WORDS-1:0][W-1:0]  key_lo;
    logic                         kd_run;

    logic [CW-1:0]                in_cnt, out_cnt;
    logic [BLK_WORDS-1:0][W-1:0]  in_head, eng_res;
    logic [0:0][W-1:0]            out_head;
    logic                         in_full, out_empty;
    logic                         wr_ctrl, flush_go;
    logic                         bus_push, dma_push, in_push1;
    logic                         bus_pop, dma_pop, out_pop1;
    logic                         blk_start, kd_start, eng_busy, eng_done, out_push;
    logic [W-1:0]                 in_word;

    assign in_full   = (in_cnt == DEPTH_C);
    assign out_empty = (out_cnt == '0);

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign flush_go = wr_ctrl && bus_wdata[10] && !bus_wdata[0] && !ctrl_q.en;

    assign bus_push = bus_wr && bus_addr == A_DIN && !in_full;
    assign dma_push = dma_in_ack && !in_full && !(bus_wr && bus_addr == A_DIN);
    assign in_push1 = bus_push || dma_push;
    assign in_word  = bus_push ? bus_wdata : dma_in_data;

    assign bus_pop  = bus_rd && bus_addr == A_DOUT && !out_empty;
    assign dma_pop  = dma_out_ack && !out_empty && !(bus_rd && bus_addr == A_DOUT);
    assign out_pop1 = bus_pop || dma_pop;

    assign blk_start = ctrl_q.en && ctrl_q.algo != ALGO_KEYPREP && !eng_busy
                       && in_cnt >= BLK_C && out_cnt <= ROOM_C;
    assign kd_start  = ctrl_q.en && ctrl_q.algo == ALGO_KEYPREP && !eng_busy && !kd_run;
    assign out_push  = eng_done && !kd_run;

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_key
        assign key_lo[g] = key_q[g];
    end

    // control, key and vector registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            dmaen_q <= '0;
            kd_run  <= 1'b0;
            iv_q    <= '0;
            for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == A_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata[9:0]);
                if (bus_addr == A_DMAEN) dmaen_q <= bus_wdata[1:0];
                for (int i = 0; i < KEY_WORDS; i++)
                    if (bus_addr == A_KEY0 + 5'(i)) key_q[i] <= bus_wdata;
                for (int i = 0; i < BLK_WORDS; i++)
                    if (bus_addr == A_IV0 + 5'(i)) iv_q[i] <= bus_wdata;
            end
            if (kd_start) kd_run <= 1'b1;
            if (eng_done && kd_run) begin
                kd_run    <= 1'b0;
                ctrl_q.en <= 1'b0;
            end
        end
    end

    word_fifo #(.W(W), .DEPTH(DEPTH), .BLK(BLK_WORDS), .PEEK(BLK_WORDS)) u_in_q (
        .clk(clk), .rst(rst), .flush(flush_go),
        .push1(in_push1), .din1(in_word),
        .push_blk(1'b0), .din_blk('0),
        .pop1(1'b0), .pop_blk(blk_start),
        .head(in_head), .count(in_cnt)
    );

    word_fifo #(.W(W), .DEPTH(DEPTH), .BLK(BLK_WORDS), .PEEK(1)) u_out_q (
        .clk(clk), .rst(rst), .flush(flush_go),
        .push1(1'b0), .din1('0),
        .push_blk(out_push), .din_blk(eng_res),
        .pop1(out_pop1), .pop_blk(1'b0),
        .head(out_head), .count(out_cnt)
    );

    stub_engine #(.W(W), .BLK(BLK_WORDS), .LAT(LATENCY)) u_eng (
        .clk(clk), .rst(rst),
        .start(blk_start || kd_start),
        .blk_in(in_head), .key(key_lo), .iv(iv_q),
        .dir(ctrl_q.dir), .lane(ctrl_q.lane),
        .busy(eng_busy), .done(eng_done), .result(eng_res)
    );

    assign dma_in_req   = ctrl_q.en && dmaen_q[0] && !in_full;
    assign dma_out_req  = dmaen_q[1] && !out_empty;
    assign dma_out_data = out_empty ? '0 : out_head[0];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = W'(ctrl_q);
            A_STAT:  bus_rdata = W'({eng_busy, !out_empty, !in_full});
            A_DMAEN: bus_rdata = W'(dmaen_q);
            A_DOUT:  bus_rdata = out_empty ? '0 : out_head[0];
            default: begin
                for (int i = 0; i < KEY_WORDS; i++)
                    if (bus_addr == A_KEY0 + 5'(i)) bus_rdata = key_q[i];
                for (int i = 0; i < BLK_WORDS; i++)
                    if (bus_addr == A_IV0 + 5'(i)) bus_rdata = iv_q[i];
            end
        endcase
    end

    AST_KD_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        eng_done && kd_run |=> !ctrl_q.en && !eng_busy); // R5
    AST_KD_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        kd_run |=> out_cnt <= $past(out_cnt)); // R5
    AST_FLUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.en |=> out_cnt + CW'(1) >= $past(out_cnt)); // R6
    AST_RESULT_FITS: assert property (@(posedge clk) disable iff (rst)
        out_push |-> out_cnt <= ROOM_C); // R4
    AST_DMA_IN_ROOM: assert property (@(posedge clk) disable iff (rst)
        dma_in_req |-> in_cnt < DEPTH_C); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == A_DOUT && out_cnt == '0 |-> bus_rdata == '0); // R9

endmodule

// File: tb/tb_cipher_ctrl_top.sv
module tb_cipher_ctrl_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        dma_in_req, dma_in_ack = 1'b0;
    logic [31:0] dma_in_data = '0;
    logic        dma_out_req, dma_out_ack = 1'b0;
    logic [31:0] dma_out_data;

    int n_chk = 0, n_bad = 0;
    logic [31:0] key_w [4];
    logic [31:0] iv_w  [4];

    always #5 clk = ~clk;

    cipher_ctrl_top #(.W(32), .DEPTH(8), .LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_in_req(dma_in_req), .dma_in_ack(dma_in_ack), .dma_in_data(dma_in_data),
        .dma_out_req(dma_out_req), .dma_out_ack(dma_out_ack), .dma_out_data(dma_out_data)
    );

    // vectors: data words, lane mode, direction, expected word 0 computed below
    localparam logic [3:0][31:0] V_DATA [4] = '{
        '{32'h0000_0004, 32'h0000_0003, 32'h0000_0002, 32'h1234_5678},
        '{32'hCAFE_0003, 32'hBEEF_0002, 32'hF00D_0001, 32'hA1B2_C3D4},
        '{32'h8000_0001, 32'h0F0F_0F0F, 32'h0000_00FF, 32'h1357_9BDF},
        '{32'hFFFF_0000, 32'h0102_0304, 32'h5555_AAAA, 32'h0000_0001}
    };
    localparam logic [1:0] V_LANE [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
    localparam logic       V_DIR  [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    function automatic logic [31:0] perm(input logic [31:0] w, input logic [1:0] m);
        logic [31:0] r;
        case (m)
            2'd1: r = {w[15:0], w[31:16]};
            2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd3: for (int b = 0; b < 32; b++) r[b] = w[31-b];
            default: r = w;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] w, input int i,
                                          input logic [1:0] m, input logic d);
        return perm(w, m) ^ key_w[i] ^ (d ? iv_w[i] : 32'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pop(output logic [31:0] v);
        @(negedge clk);
        bus_addr = 5'd4; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load_keys(input int seed);
        for (int i = 0; i < 4; i++) begin
            key_w[i] = 32'h1111_0000 * (seed + 1) + 32'(i * 7);
            iv_w[i]  = 32'h0F00_00A0 + 32'(seed * 16 + i);
            wr(5'(8 + i), key_w[i]);
            wr(5'(16 + i), iv_w[i]);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic en, input logic d,
                                              input logic [3:0] algo, input logic [1:0] m);
        return {22'd0, m, 2'd0, algo, d, en};
    endfunction

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(5'd0, v); chk("R1 ctrl", v, 32'h0);
        peek(5'd1, v); chk("R1 stat", v, 32'h1);
        peek(5'd2, v); chk("R1 dmaen", v, 32'h0);
        chk("R1 dma reqs", {30'd0, dma_in_req, dma_out_req}, 32'h0);

        // R2 readback, flush bit reads zero
        wr(5'd0, 32'h0000_06D8);
        peek(5'd0, v); chk("R2 ctrl", v, 32'h0000_02D8);
        wr(5'd13, 32'hDEAD_BEEF);
        peek(5'd13, v); chk("R2 key5", v, 32'hDEAD_BEEF);
        wr(5'd19, 32'h0BAD_F00D);
        peek(5'd19, v); chk("R2 iv3", v, 32'h0BAD_F00D);
        wr(5'd2, 32'h3);
        peek(5'd2, v); chk("R2 dmaen", v, 32'h3);
        wr(5'd2, 32'h0);
        wr(5'd0, 32'h0);

        // R3 table of vectors
        for (int k = 0; k < 4; k++) begin
            wr(5'd0, 32'h0);
            load_keys(k);
            wr(5'd0, ctrl_word(1'b1, V_DIR[k], 4'd2, V_LANE[k]));
            for (int i = 0; i < 4; i++) wr(5'd3, V_DATA[k][i]);
            repeat (LAT + 2) @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                pop(v);
                chk($sformatf("R3 vec%0d word%0d", k, i), v,
                    model(V_DATA[k][i], i, V_LANE[k], V_DIR[k]));
            end
        end

        // R4 and R7 cycle timing from the fourth queued word
        for (int i = 0; i < 3; i++) wr(5'd3, 32'h100 + 32'(i));
        peek(5'd1, v); chk("R7 stat before block", v, 32'h1);
        wr(5'd3, 32'h103);
        peek(5'd1, v); chk("R4 not yet busy", v, 32'h1);
        @(negedge clk);
        peek(5'd1, v); chk("R4 busy after accept", v, 32'h5);
        repeat (LAT - 1) @(negedge clk);
        peek(5'd1, v); chk("R4 busy last cycle", v, 32'h5);
        @(negedge clk);
        peek(5'd1, v); chk("R4 R7 result ready", v, 32'h3);
        for (int i = 0; i < 4; i++) begin
            pop(v);
            chk("R4 data", v, model(32'h100 + 32'(i), i, V_LANE[3], V_DIR[3]));
        end

        // R5 key preparation
        wr(5'd0, ctrl_word(1'b1, 1'b1, 4'd7, 2'd2));
        peek(5'd1, v); chk("R5 not yet busy", v, 32'h1);
        @(negedge clk);
        peek(5'd1, v); chk("R5 busy", v, 32'h5);
        repeat (LAT) @(negedge clk);
        peek(5'd1, v); chk("R5 busy cleared, no output", v, 32'h1);
        peek(5'd0, v); chk("R5 enable cleared", v, ctrl_word(1'b0, 1'b1, 4'd7, 2'd2));

        // R6 flush ignored while enabled
        wr(5'd0, ctrl_word(1'b1, 1'b0, 4'd2, 2'd0));
        for (int i = 0; i < 3; i++) wr(5'd3, 32'hA0 + 32'(i));
        wr(5'd0, ctrl_word(1'b1, 1'b0, 4'd2, 2'd0) | 32'h400);
        wr(5'd3, 32'hA3);
        repeat (LAT + 2) @(negedge clk);
        peek(5'd1, v); chk("R6 enabled flush ignored", v, 32'h3);
        pop(v); chk("R6 data kept", v, model(32'hA0, 0, 2'd0, 1'b0));
        // R6 flush while disabled empties both queues
        wr(5'd0, 32'h0);
        wr(5'd3, 32'hB0);
        wr(5'd3, 32'hB1);
        wr(5'd0, 32'h400);
        peek(5'd1, v); chk("R6 both queues empty", v, 32'h1);
        wr(5'd0, ctrl_word(1'b1, 1'b0, 4'd2, 2'd0));
        for (int i = 0; i < 4; i++) wr(5'd3, 32'hC0 + 32'(i));
        repeat (LAT + 2) @(negedge clk);
        pop(v); chk("R6 old input gone", v, model(32'hC0, 0, 2'd0, 1'b0));
        for (int i = 1; i < 4; i++) pop(v);

        // R9 and R10: overfill, two blocks in order, empty read
        wr(5'd0, ctrl_word(1'b0, 1'b0, 4'd2, 2'd0));
        for (int i = 0; i < 9; i++) wr(5'd3, 32'hD0 + 32'(i));
        peek(5'd1, v); chk("R7 R9 input full", v, 32'h0);
        wr(5'd0, ctrl_word(1'b1, 1'b0, 4'd2, 2'd0));
        repeat (2 * LAT + 4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pop(v);
            chk($sformatf("R10 order word%0d", i), v, model(32'hD0 + 32'(i), i % 4, 2'd0, 1'b0));
        end
        pop(v); chk("R9 empty read zero", v, 32'h0);
        peek(5'd1, v); chk("R9 overflow word dropped", v, 32'h1);

        // R8 DMA
        wr(5'd2, 32'h3);
        chk("R8 in req", {31'd0, dma_in_req}, 32'h1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dma_in_ack = 1'b1; dma_in_data = 32'hE0 + 32'(i);
        end
        @(negedge clk);
        dma_in_ack = 1'b0;
        chk("R8 no out req yet", {31'd0, dma_out_req}, 32'h0);
        repeat (LAT + 1) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R8 out req", {31'd0, dma_out_req}, 32'h1);
            chk("R8 out data", dma_out_data, model(32'hE0 + 32'(i), i, 2'd0, 1'b0));
            dma_out_ack = 1'b1;
            @(negedge clk);
            dma_out_ack = 1'b0;
        end
        chk("R8 out req drops", {31'd0, dma_out_req}, 32'h0);
        wr(5'd0, 32'h0);
        chk("R8 in req off when disabled", {31'd0, dma_in_req}, 32'h0);

        // R1 reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        peek(5'd2, v); chk("R1 dmaen after reset", v, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule